// File: doc/BRIEF.md
# Cascadable Serial Configuration ROM

This block is a read-only store that feeds a fixed configuration bitstream, one bit per clock, to a device that is loading its configuration. The loader supplies the clock and decides how many pulses to give. While the chip enable is active, every rising edge moves the read position forward and registers the next stored bit onto the serial data output. When the loader has what it needs, it drops the chip enable and the ROM lets go of the data line straight away.

Several of these ROMs can be chained to hold a stream longer than one device. They share one clock net and one data net. The cascade output of each device drives the chip enable of the next. A device raises its cascade output on the same edge that presents its final bit. On the following edge it lets go of the data line, and the next device presents its first bit on that same edge. The result is a seamless stream with no gap.

The data output is split into a value and a drive enable, so the pad-level tri-state buffer sits with the chip's I/O ring. The stored contents and the depth are parameters. A parameter also chooses which level of the reset pin counts as active.

Top module: `serial_cfg_rom`

## Requirements
- R1: Content bit 0 is streamed first. On the k-th rising edge with `ce` high and no reset since the last reset (k = 1..DEPTH), `data_out` takes content bit k-1 and `data_oe` is 1.
- R2: `data_oe` is 0 whenever `ce` is 0, in the same cycle that `ce` falls, with no clock edge needed.
- R3: Rising edges with `ce` at 0 do not move the read position or change `ceo`. After `ce` returns, the stream continues with the next bit in order.
- R4: `ceo` goes to 1 on the edge that presents content bit DEPTH-1. It stays 1, whatever `ce` does, until a reset.
- R5: From the first enabled edge after the last bit was presented, `data_oe` stays 0 until a reset.
- R6: When `rst_in` equals the `RST_LEVEL` parameter at a rising edge, the read position returns to bit 0 and `ceo` and `data_oe` go to 0, whatever `ce` is. The other level of `rst_in` has no effect.
- R7: In a chain where the first device's `ceo` drives the second device's `ce`, the shared line carries all bits of the first device and then all bits of the second, with no idle cycle between them. The two devices never drive the line at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock from the loader |
| rst_in | input | 1 | Synchronous reset; its active level is set by `RST_LEVEL` |
| ce | input | 1 | Chip enable, active high; driven by the loader or by the previous `ceo` |
| data_out | output | 1 | Serial data value; meaningful only while `data_oe` is 1 |
| data_oe | output | 1 | Drive enable for the shared data line |
| ceo | output | 1 | Cascade enable for the next device in the chain |

## Verification
On every cycle, the assertions check four things: `data_oe` never rises without `ce`, `ceo` is sticky, the read position holds when `ce` is idle, and a reset clears the outputs. They also check that the position advances by one per enabled edge and that the line is released after the final bit. Only the bench's scenarios can show that the stream carries the stored contents in the right order across two chained devices with no gap. The same goes for resuming correctly after a stall, restarting from bit 0 after a mid-stream reset, and treating the opposite reset level as inert on an active-low instance.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

  // Sequencer states: bit 0 = driving the line, bit 1 = cascade raised
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_SEND = 2'b01,
    SEQ_LAST = 2'b11,
    SEQ_GONE = 2'b10
  } seq_state_t;

  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/cfg_rom_rst_norm.sv
// Turns the raw reset pin into an active-high reset, using the chosen level
module cfg_rom_rst_norm #(
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic rst_pin,
  output logic rst_act
);
  generate
    if (RST_LEVEL) begin : g_high
      assign rst_act = rst_pin;
    end else begin : g_low
      assign rst_act = ~rst_pin;
    end
  endgenerate
endmodule

// File: rtl/cfg_rom_ptr.sv
// Read position counter; saturates at the final bit
module cfg_rom_ptr #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_act,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  assign at_last = (ptr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst_act) begin
      ptr <= '0;
    end else if (step && !at_last) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_rom_bits.sv
// Constant bit store with a registered read port (ROM inference friendly)
module cfg_rom_bits #(
  parameter int unsigned      DEPTH  = 16,
  parameter int unsigned      ADDR_W = 4,
  parameter logic [DEPTH-1:0] INIT   = '0
) (
  input  logic              clk,
  input  logic              rst_act,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);
  logic store [DEPTH];

  generate
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
      assign store[gi] = INIT[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst_act) begin
      rd_bit <= 1'b0;
    end else if (rd_en) begin
      rd_bit <= store[rd_addr];
    end
  end
endmodule

// File: rtl/cfg_rom_seq.sv
// Tracks whether this device is driving the line and when to pass control on
module cfg_rom_seq
  import cfg_rom_pkg::*;
(
  input  logic clk,
  input  logic rst_act,
  input  logic step,
  input  logic at_last,
  output logic drive_q,
  output logic cascade_q
);
  seq_state_t state, state_nx;

  always_comb begin
    state_nx = state;
    if (step) begin
      unique case (state)
        SEQ_IDLE: state_nx = at_last ? SEQ_LAST : SEQ_SEND;
        SEQ_SEND: state_nx = at_last ? SEQ_LAST : SEQ_SEND;
        SEQ_LAST: state_nx = SEQ_GONE;
        SEQ_GONE: state_nx = SEQ_GONE;
        default:  state_nx = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_act) begin
      state <= SEQ_IDLE;
    end else begin
      state <= state_nx;
    end
  end

  assign drive_q   = state[0];
  assign cascade_q = state[1];
endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom #(
  parameter int unsigned      DEPTH     = 16,
  parameter logic [DEPTH-1:0] INIT      = 16'hC35A,
  parameter logic             RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_in,
  input  logic ce,
  output logic data_out,
  output logic data_oe,
  output logic ceo
);
  localparam int unsigned ADDR_W = cfg_rom_pkg::ptr_width(DEPTH);

  logic              rst_act;
  logic              step;
  logic              at_last;
  logic              drive_q;
  logic [ADDR_W-1:0] rd_ptr;

  cfg_rom_rst_norm #(.RST_LEVEL(RST_LEVEL)) u_rst (
    .rst_pin (rst_in),
    .rst_act (rst_act)
  );

  assign step = ce & ~rst_act;

  cfg_rom_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_act (rst_act),
    .step    (step),
    .ptr     (rd_ptr),
    .at_last (at_last)
  );

  cfg_rom_bits #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .INIT(INIT)) u_bits (
    .clk     (clk),
    .rst_act (rst_act),
    .rd_en   (step),
    .rd_addr (rd_ptr),
    .rd_bit  (data_out)
  );

  cfg_rom_seq u_seq (
    .clk       (clk),
    .rst_act   (rst_act),
    .step      (step),
    .at_last   (at_last),
    .drive_q   (drive_q),
    .cascade_q (ceo)
  );

  // Release of the shared line follows ce without waiting for an edge
  assign data_oe = drive_q & ce;
endmodule

// File: rtl/serial_cfg_rom_chk.sv
module serial_cfg_rom_chk #(
  parameter int unsigned DEPTH     = 16,
  parameter logic        RST_LEVEL = 1'b1,
  parameter int unsigned ADDR_W    = 4
) (
  input logic              clk,
  input logic              rst_in,
  input logic              ce,
  input logic              data_oe,
  input logic              ceo,
  input logic [ADDR_W-1:0] rd_ptr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic rst_act;
  assign rst_act = (rst_in == RST_LEVEL);

  // R2
  a_r2_oe_needs_ce: assert property (@(posedge clk) data_oe |-> ce);

  // R4
  a_r4_ceo_sticky: assert property (@(posedge clk) disable iff (rst_act)
    ceo |=> ceo);

  // R3
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst_act)
    !ce |=> ($stable(rd_ptr) && $stable(ceo)));

  // R1
  a_r1_ptr_advance: assert property (@(posedge clk) disable iff (rst_act)
    (ce && rd_ptr != LAST_ADDR) |=> (rd_ptr == $past(rd_ptr) + 1'b1));

  // R5
  a_r5_release_after_end: assert property (@(posedge clk) disable iff (rst_act)
    (ce && ceo) |=> !data_oe);

  // R6
  a_r6_reset_clears: assert property (@(posedge clk)
    rst_act |=> (!ceo && !data_oe && rd_ptr == '0));
endmodule

bind serial_cfg_rom serial_cfg_rom_chk #(
  .DEPTH     (DEPTH),
  .RST_LEVEL (RST_LEVEL),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst_in  (rst_in),
  .ce      (ce),
  .data_oe (data_oe),
  .ceo     (ceo),
  .rd_ptr  (rd_ptr)
);

// File: tb/test_serial_cfg_rom.sv
module test_serial_cfg_rom;
  localparam int unsigned DA = 12;
  localparam logic [DA-1:0] IA = 12'hB3C;
  localparam int unsigned DB = 20;
  localparam logic [DB-1:0] IB = 20'h5A1F6;
  localparam int unsigned DC = 8;
  localparam logic [DC-1:0] IC = 8'hA5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, ce = 1'b0;
  logic a_d, a_oe, a_ceo, b_d, b_oe, b_ceo;
  logic c_rst_n = 1'b0, c_ce = 1'b0, c_d, c_oe, c_ceo;

  serial_cfg_rom #(.DEPTH(DA), .INIT(IA), .RST_LEVEL(1'b1)) i_serial_cfg_rom (
    .clk(clk), .rst_in(rst), .ce(ce), .data_out(a_d), .data_oe(a_oe), .ceo(a_ceo));
  serial_cfg_rom #(.DEPTH(DB), .INIT(IB), .RST_LEVEL(1'b1)) i_serial_cfg_rom_b (
    .clk(clk), .rst_in(rst), .ce(a_ceo), .data_out(b_d), .data_oe(b_oe), .ceo(b_ceo));
  serial_cfg_rom #(.DEPTH(DC), .INIT(IC), .RST_LEVEL(1'b0)) i_serial_cfg_rom_n (
    .clk(clk), .rst_in(c_rst_n), .ce(c_ce), .data_out(c_d), .data_oe(c_oe), .ceo(c_ceo));

  int n_run = 0, n_fail = 0;
  bit exp_q[$];
  bit mon_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // driver: expected chained stream, device A first then device B
  task automatic push_chain();
    for (int i = 0; i < DA; i++) exp_q.push_back(IA[i]);
    for (int i = 0; i < DB; i++) exp_q.push_back(IB[i]);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // monitor: compares the resolved shared line against the scoreboard
  always begin
    @(posedge clk); #1;
    if (mon_on) begin
      if (a_oe && b_oe) chk("R7 both driving", 1'b1, 1'b0);
      if (a_oe || b_oe) begin
        if (exp_q.size() == 0) begin
          chk("R5 extra bit on line", 1'b1, 1'b0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          if (a_oe) chk("R1 device A bit", a_d, e);
          else      chk("R7 device B bit", b_d, e);
        end
      end else if (exp_q.size() != 0 && (ce || a_ceo)) begin
        chk("R7 idle gap in stream", 1'b0, 1'b1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) tick();
    chk("R6 reset oe A", a_oe, 1'b0);
    chk("R6 reset ceo A", a_ceo, 1'b0);
    chk("R6 reset oe B", b_oe, 1'b0);
    chk("R6 reset ceo B", b_ceo, 1'b0);
    @(negedge clk) rst = 1'b0;

    // full chain with a stall inside device A
    push_chain();
    mon_on = 1'b1;
    @(negedge clk) ce = 1'b1;
    repeat (5) tick();
    @(negedge clk) ce = 1'b0;
    #1 chk("R2 immediate release", a_oe, 1'b0);
    repeat (3) begin
      tick();
      chk("R3 stall no drive", a_oe, 1'b0);
      chk("R3 stall no cascade", a_ceo, 1'b0);
    end
    @(negedge clk) ce = 1'b1;
    while (exp_q.size() != 0) tick();
    repeat (3) tick();
    chk("R5 A released", a_oe, 1'b0);
    chk("R5 B released", b_oe, 1'b0);
    chk("R4 A cascade", a_ceo, 1'b1);
    chk("R4 B cascade", b_ceo, 1'b1);
    @(negedge clk) ce = 1'b0;
    repeat (2) tick();
    chk("R4 cascade sticky", a_ceo, 1'b1);
    mon_on = 1'b0;

    // reset with ce held high, mid-stream, then restart from bit 0
    @(negedge clk) begin rst = 1'b1; ce = 1'b1; end
    tick();
    @(negedge clk) rst = 1'b0;
    repeat (4) tick();
    @(negedge clk) rst = 1'b1;
    tick();
    chk("R6 mid reset oe", a_oe, 1'b0);
    chk("R6 mid reset ceo", a_ceo, 1'b0);
    chk("R6 mid reset B ceo", b_ceo, 1'b0);
    push_chain();
    mon_on = 1'b1;
    @(negedge clk) rst = 1'b0;
    while (exp_q.size() != 0) tick();
    repeat (2) tick();
    chk("R7 chain complete", b_ceo, 1'b1);
    mon_on = 1'b0;

    // active-low reset instance
    repeat (2) tick();
    chk("R6 low-level reset oe", c_oe, 1'b0);
    chk("R6 low-level reset ceo", c_ceo, 1'b0);
    @(negedge clk) begin c_rst_n = 1'b1; c_ce = 1'b1; end
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 high level inert oe", c_oe, 1'b1);
      chk("R1 C bit", c_d, IC[i]);
    end
    @(negedge clk) c_rst_n = 1'b0;
    tick();
    chk("R6 low reset clears oe", c_oe, 1'b0);
    chk("R6 low reset clears ceo", c_ceo, 1'b0);
    @(negedge clk) c_rst_n = 1'b1;
    tick();
    chk("R6 restart at bit 0", c_d, IC[0]);
    for (int i = 1; i < DC; i++) begin
      tick();
      chk("R1 C stream bit", c_d, IC[i]);
      chk("R4 ceo on last edge", c_ceo, (i == DC - 1) ? 1'b1 : 1'b0);
    end
    chk("R4 last bit still driven", c_oe, 1'b1);
    tick();
    chk("R5 release after last", c_oe, 1'b0);
    chk("R4 ceo held", c_ceo, 1'b1);
    done = 1'b1;
    finish_run();
  end
endmodule